// File: doc/BRIEF.md
# SIMT Branch Reconvergence Stack

This block keeps the divergence state of one warp. Every entry of its stack holds three things: the PC the warp will fetch next, the PC where that entry's threads join up again, and a mask of the lanes that are live on that path. The entry on top of the stack supplies the fetch PC and the lane mask. Lanes whose bit is clear in the top mask do not execute the instructions on that path.

On a branch, the taken mask is first limited to the live lanes. There are then two cases:
- If the branch is uniform, only the top entry's PC moves, and nothing is pushed.
- If the branch diverges, the top entry is rewritten to wait at the reconvergence PC with the full pre-branch mask. Two entries are then pushed: the not-taken path first and the taken path last, so the taken path runs first.

Each time the warp advances, its new PC is reported through the step input. When that PC equals the top entry's reconvergence PC, the top entry is popped. When all path entries have been popped, the original mask is back at the reconvergence PC.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack holds no entries. `depth` is 0, `fetch_pc` is 0, `active_mask` is 0 and `overflow` is 0.
- R2: A load request replaces the whole stack with one base entry, which holds the given PC and mask and an all-ones reconvergence PC. The load request also clears `overflow`.
- R3: `fetch_pc` and `active_mask` show the top entry, starting in the cycle after the clock edge that changed that entry. While `depth` is 0, both outputs read 0.
- R4: A branch is uniform when `taken & active_mask` is zero or equals `active_mask`. A uniform branch pushes nothing. It sets the top PC to `br_target` if the lanes go taken and to `br_fallthru` if they do not, and it leaves the top mask unchanged. Taken bits of inactive lanes are ignored.
- R5: A divergent branch performs three writes and raises `depth` by 2:
  - The top entry's PC becomes `br_reconv`, and it keeps its mask.
  - The not-taken entry is pushed with PC `br_fallthru` and mask `active & ~taken`.
  - The taken entry is pushed last, with PC `br_target` and mask `active & taken`.
  - Both pushed entries carry `br_reconv` as their reconvergence PC.
- R6: A step whose PC equals the top entry's reconvergence PC pops that entry when `depth` > 1. Any other step writes the step PC into the top entry.
- R7: The base entry is never popped, even when a step PC equals its all-ones reconvergence PC.
- R8: If a divergent branch would take `depth` above DEPTH, the stack is left unchanged and `overflow` is set. `overflow` stays set until the next load.
- R9: While `depth` is 0, branch and step requests have no effect.
- R10: When several requests arrive in the same cycle, load wins over branch, and branch wins over step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Start a warp with one base entry |
| load_pc | input | PC_W | Start PC of the warp |
| load_mask | input | LANES | Lanes of the warp that start live |
| br_valid | input | 1 | A branch has resolved |
| br_taken | input | LANES | Per-lane taken outcome |
| br_target | input | PC_W | Taken target PC |
| br_fallthru | input | PC_W | Not-taken PC |
| br_reconv | input | PC_W | Reconvergence PC of this branch |
| step_valid | input | 1 | The warp advanced to a new PC |
| step_pc | input | PC_W | The PC the warp reached |
| fetch_pc | output | PC_W | Next PC, from the top entry |
| active_mask | output | LANES | Live lanes, from the top entry |
| depth | output | $clog2(DEPTH+1) | Number of stack entries |
| overflow | output | 1 | Sticky flag: a divergent push was refused |

## Verification
The branch logic is driven with four kinds of taken mask:
- all live lanes taken, which must follow the target;
- no lanes taken, which must follow the fall-through;
- taken bits only on inactive lanes, which must count as not taken;
- a split mask, which must push two entries with complementary masks and run the taken half first.

Step PCs are sent that hit and that miss the top reconvergence PC. These separate a pop from a plain PC update, and they confirm that the base entry survives a step equal to its all-ones sentinel. A nested split is attempted at full depth to prove that an overflow changes no state. Requests are also sent in the same cycle and while the stack is empty, to test priority and the empty state.

// File: rtl/simt_stk_pkg.sv
package simt_stk_pkg;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_LOAD   = 2'd1,
      ACT_BRANCH = 2'd2,
      ACT_STEP   = 2'd3
   } stk_act_e;

   localparam int unsigned NUM_WR_PORTS = 3;

endpackage

// File: rtl/simt_br_classify.sv
module simt_br_classify #(
   parameter int unsigned LANES = 32
) (
   input  logic [LANES-1:0] active,
   input  logic [LANES-1:0] taken,
   output logic [LANES-1:0] tk_mask,
   output logic [LANES-1:0] nt_mask,
   output logic             uniform,
   output logic             all_taken
);
   always_comb begin
      tk_mask   = active & taken;
      nt_mask   = active & ~taken;
      all_taken = (tk_mask == active);
      uniform   = (tk_mask == '0) || all_taken;
   end
endmodule

// File: rtl/simt_stk_store.sv
module simt_stk_store #(
   parameter int unsigned LANES         = 32,
   parameter int unsigned PC_W          = 32,
   parameter int unsigned DEPTH         = 8,
   parameter int unsigned CNT_W         = 4,
   parameter bit          RESET_ENTRIES = 1'b1
) (
   input  logic                                             clk,
   input  logic                                             rst_n,
   input  logic [simt_stk_pkg::NUM_WR_PORTS-1:0]            we,
   input  logic [simt_stk_pkg::NUM_WR_PORTS-1:0][CNT_W-1:0] widx,
   input  logic [simt_stk_pkg::NUM_WR_PORTS-1:0][PC_W-1:0]  wpc,
   input  logic [simt_stk_pkg::NUM_WR_PORTS-1:0][PC_W-1:0]  wrpc,
   input  logic [simt_stk_pkg::NUM_WR_PORTS-1:0][LANES-1:0] wmask,
   input  logic [CNT_W-1:0]                                 ridx,
   output logic [PC_W-1:0]                                  rd_pc,
   output logic [PC_W-1:0]                                  rd_rpc,
   output logic [LANES-1:0]                                 rd_mask
);
   localparam int unsigned NW = simt_stk_pkg::NUM_WR_PORTS;

   logic [DEPTH-1:0][PC_W-1:0]  pc_q;
   logic [DEPTH-1:0][PC_W-1:0]  rpc_q;
   logic [DEPTH-1:0][LANES-1:0] mask_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [PC_W-1:0]  pc_d;
      logic [PC_W-1:0]  rpc_d;
      logic [LANES-1:0] mask_d;

      always_comb begin
         pc_d   = pc_q[i];
         rpc_d  = rpc_q[i];
         mask_d = mask_q[i];
         for (int p = NW - 1; p >= 0; p--) begin
            if (we[p] && (widx[p] == CNT_W'(i))) begin
               pc_d   = wpc[p];
               rpc_d  = wrpc[p];
               mask_d = wmask[p];
            end
         end
      end

      if (RESET_ENTRIES) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pc_q[i]   <= '0;
               rpc_q[i]  <= '0;
               mask_q[i] <= '0;
            end else begin
               pc_q[i]   <= pc_d;
               rpc_q[i]  <= rpc_d;
               mask_q[i] <= mask_d;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            pc_q[i]   <= pc_d;
            rpc_q[i]  <= rpc_d;
            mask_q[i] <= mask_d;
         end
      end
   end

   always_comb begin
      rd_pc   = '0;
      rd_rpc  = '0;
      rd_mask = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (ridx == CNT_W'(i)) begin
            rd_pc   = pc_q[i];
            rd_rpc  = rpc_q[i];
            rd_mask = mask_q[i];
         end
      end
   end
endmodule

// File: rtl/simt_stk_ctrl.sv
module simt_stk_ctrl #(
   parameter int unsigned LANES = 32,
   parameter int unsigned PC_W  = 32,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = 4
) (
   input  logic                                             clk,
   input  logic                                             rst_n,
   input  logic                                             load_valid,
   input  logic [PC_W-1:0]                                  load_pc,
   input  logic [LANES-1:0]                                 load_mask,
   input  logic                                             br_valid,
   input  logic [PC_W-1:0]                                  br_target,
   input  logic [PC_W-1:0]                                  br_fallthru,
   input  logic [PC_W-1:0]                                  br_reconv,
   input  logic                                             step_valid,
   input  logic [PC_W-1:0]                                  step_pc,
   input  logic [PC_W-1:0]                                  top_pc,
   input  logic [PC_W-1:0]                                  top_rpc,
   input  logic [LANES-1:0]                                 top_mask,
   input  logic                                             uniform,
   input  logic                                             all_taken,
   input  logic [LANES-1:0]                                 tk_mask,
   input  logic [LANES-1:0]                                 nt_mask,
   output logic [simt_stk_pkg::NUM_WR_PORTS-1:0]            we,
   output logic [simt_stk_pkg::NUM_WR_PORTS-1:0][CNT_W-1:0] widx,
   output logic [simt_stk_pkg::NUM_WR_PORTS-1:0][PC_W-1:0]  wpc,
   output logic [simt_stk_pkg::NUM_WR_PORTS-1:0][PC_W-1:0]  wrpc,
   output logic [simt_stk_pkg::NUM_WR_PORTS-1:0][LANES-1:0] wmask,
   output logic [CNT_W-1:0]                                 cnt,
   output logic [CNT_W-1:0]                                 top_idx,
   output logic                                             ovf
);
   import simt_stk_pkg::*;

   logic [CNT_W-1:0] cnt_d;
   logic             ovf_d;
   stk_act_e         act;
   logic             room2;

   assign top_idx = cnt - CNT_W'(1);
   assign room2   = (int'(cnt) + 2) <= int'(DEPTH);

   always_comb begin
      if (load_valid)                    act = ACT_LOAD;
      else if (br_valid && cnt != '0)    act = ACT_BRANCH;
      else if (step_valid && cnt != '0)  act = ACT_STEP;
      else                               act = ACT_NONE;
   end

   always_comb begin
      we    = '0;
      widx  = '0;
      wpc   = '0;
      wrpc  = '0;
      wmask = '0;
      cnt_d = cnt;
      ovf_d = ovf;
      unique case (act)
         ACT_LOAD: begin
            we[0]    = 1'b1;
            wpc[0]   = load_pc;
            wrpc[0]  = '1;
            wmask[0] = load_mask;
            cnt_d    = CNT_W'(1);
            ovf_d    = 1'b0;
         end
         ACT_BRANCH: begin
            if (uniform) begin
               we[0]    = 1'b1;
               widx[0]  = top_idx;
               wpc[0]   = all_taken ? br_target : br_fallthru;
               wrpc[0]  = top_rpc;
               wmask[0] = top_mask;
            end else if (!room2) begin
               ovf_d = 1'b1;
            end else begin
               we       = '1;
               widx[0]  = top_idx;
               wpc[0]   = br_reconv;
               wrpc[0]  = top_rpc;
               wmask[0] = top_mask;
               widx[1]  = cnt;
               wpc[1]   = br_fallthru;
               wrpc[1]  = br_reconv;
               wmask[1] = nt_mask;
               widx[2]  = cnt + CNT_W'(1);
               wpc[2]   = br_target;
               wrpc[2]  = br_reconv;
               wmask[2] = tk_mask;
               cnt_d    = cnt + CNT_W'(2);
            end
         end
         ACT_STEP: begin
            if (step_pc == top_rpc && cnt > CNT_W'(1)) begin
               cnt_d = cnt - CNT_W'(1);
            end else begin
               we[0]    = 1'b1;
               widx[0]  = top_idx;
               wpc[0]   = step_pc;
               wrpc[0]  = top_rpc;
               wmask[0] = top_mask;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         cnt <= cnt_d;
         ovf <= ovf_d;
      end
   end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
   parameter int unsigned LANES         = 32,
   parameter int unsigned PC_W          = 32,
   parameter int unsigned DEPTH         = 8,
   parameter bit          RESET_ENTRIES = 1'b1,
   localparam int unsigned CNT_W        = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_valid,
   input  logic [PC_W-1:0]  load_pc,
   input  logic [LANES-1:0] load_mask,
   input  logic             br_valid,
   input  logic [LANES-1:0] br_taken,
   input  logic [PC_W-1:0]  br_target,
   input  logic [PC_W-1:0]  br_fallthru,
   input  logic [PC_W-1:0]  br_reconv,
   input  logic             step_valid,
   input  logic [PC_W-1:0]  step_pc,
   output logic [PC_W-1:0]  fetch_pc,
   output logic [LANES-1:0] active_mask,
   output logic [CNT_W-1:0] depth,
   output logic             overflow
);
   localparam int unsigned NW = simt_stk_pkg::NUM_WR_PORTS;

   if (LANES < 1)  begin : g_bad_lanes  $error("LANES must be at least 1");  end
   if (PC_W < 2)   begin : g_bad_pcw    $error("PC_W must be at least 2");   end
   if (DEPTH < 3)  begin : g_bad_depth  $error("DEPTH must be at least 3");  end

   logic [PC_W-1:0]            top_pc;
   logic [PC_W-1:0]            top_rpc;
   logic [LANES-1:0]           top_mask;
   logic [LANES-1:0]           tk_mask;
   logic [LANES-1:0]           nt_mask;
   logic                       uniform;
   logic                       all_taken;
   logic [NW-1:0]              we;
   logic [NW-1:0][CNT_W-1:0]   widx;
   logic [NW-1:0][PC_W-1:0]    wpc;
   logic [NW-1:0][PC_W-1:0]    wrpc;
   logic [NW-1:0][LANES-1:0]   wmask;
   logic [CNT_W-1:0]           cnt;
   logic [CNT_W-1:0]           top_idx;
   logic                       ovf;

   simt_br_classify #(.LANES(LANES)) u_cls (
      .active    (top_mask),
      .taken     (br_taken),
      .tk_mask   (tk_mask),
      .nt_mask   (nt_mask),
      .uniform   (uniform),
      .all_taken (all_taken)
   );

   simt_stk_ctrl #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_valid  (load_valid),
      .load_pc     (load_pc),
      .load_mask   (load_mask),
      .br_valid    (br_valid),
      .br_target   (br_target),
      .br_fallthru (br_fallthru),
      .br_reconv   (br_reconv),
      .step_valid  (step_valid),
      .step_pc     (step_pc),
      .top_pc      (top_pc),
      .top_rpc     (top_rpc),
      .top_mask    (top_mask),
      .uniform     (uniform),
      .all_taken   (all_taken),
      .tk_mask     (tk_mask),
      .nt_mask     (nt_mask),
      .we          (we),
      .widx        (widx),
      .wpc         (wpc),
      .wrpc        (wrpc),
      .wmask       (wmask),
      .cnt         (cnt),
      .top_idx     (top_idx),
      .ovf         (ovf)
   );

   simt_stk_store #(
      .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .CNT_W(CNT_W),
      .RESET_ENTRIES(RESET_ENTRIES)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we),
      .widx    (widx),
      .wpc     (wpc),
      .wrpc    (wrpc),
      .wmask   (wmask),
      .ridx    (top_idx),
      .rd_pc   (top_pc),
      .rd_rpc  (top_rpc),
      .rd_mask (top_mask)
   );

   assign fetch_pc    = (cnt != '0) ? top_pc   : '0;
   assign active_mask = (cnt != '0) ? top_mask : '0;
   assign depth       = cnt;
   assign overflow    = ovf;
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
   parameter int unsigned LANES = 32,
   parameter int unsigned PC_W  = 32,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_valid,
   input logic             br_valid,
   input logic             step_valid,
   input logic [PC_W-1:0]  fetch_pc,
   input logic [LANES-1:0] active_mask,
   input logic [CNT_W-1:0] depth,
   input logic             overflow
);
   a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(depth) <= int'(DEPTH));

   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !load_valid) |=> overflow);

   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (depth != '0 && !load_valid) |=> depth != '0);

   a_r9_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (depth == '0 && !load_valid) |=> depth == '0);

   a_r3_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (depth == '0) |-> (fetch_pc == '0 && active_mask == '0));

   a_r4_mask_narrows: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !load_valid && depth != '0) |=>
      ((active_mask & ~$past(active_mask)) == '0));

   a_r6_step_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && !br_valid && !load_valid) |=> depth <= $past(depth));

   a_r2_load_one: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |=> (depth == CNT_W'(1) && !overflow));
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
   .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .load_valid  (load_valid),
   .br_valid    (br_valid),
   .step_valid  (step_valid),
   .fetch_pc    (fetch_pc),
   .active_mask (active_mask),
   .depth       (depth),
   .overflow    (overflow)
);

// File: tb/simt_reconv_stack_tb.sv
module simt_reconv_stack_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned LANES = 32;
   localparam int unsigned PC_W  = 32;
   localparam int unsigned DEPTH = 4;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   localparam logic [1:0] OP_LOAD = 2'd1;
   localparam logic [1:0] OP_BR   = 2'd2;
   localparam logic [1:0] OP_STEP = 2'd3;

   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] m;
      logic [31:0] p1;
      logic [31:0] p2;
      logic [31:0] p3;
      logic [31:0] e_pc;
      logic [31:0] e_mask;
      logic [3:0]  e_depth;
      logic        e_ovf;
   } vec_t;

   localparam int NVEC = 19;
   localparam vec_t VEC [NVEC] = '{
      '{OP_LOAD, 32'hFFFF_FFFF, 32'h100, 32'h0,   32'h0,   32'h100, 32'hFFFF_FFFF, 4'd1, 1'b0},
      '{OP_STEP, 32'h0,         32'h104, 32'h0,   32'h0,   32'h104, 32'hFFFF_FFFF, 4'd1, 1'b0},
      '{OP_BR,   32'h0000_FFFF, 32'h200, 32'h108, 32'h300, 32'h200, 32'h0000_FFFF, 4'd3, 1'b0},
      '{OP_STEP, 32'h0,         32'h204, 32'h0,   32'h0,   32'h204, 32'h0000_FFFF, 4'd3, 1'b0},
      '{OP_STEP, 32'h0,         32'h300, 32'h0,   32'h0,   32'h108, 32'hFFFF_0000, 4'd2, 1'b0},
      '{OP_STEP, 32'h0,         32'h10C, 32'h0,   32'h0,   32'h10C, 32'hFFFF_0000, 4'd2, 1'b0},
      '{OP_STEP, 32'h0,         32'h300, 32'h0,   32'h0,   32'h300, 32'hFFFF_FFFF, 4'd1, 1'b0},
      '{OP_BR,   32'hFFFF_FFFF, 32'h400, 32'h304, 32'h500, 32'h400, 32'hFFFF_FFFF, 4'd1, 1'b0},
      '{OP_BR,   32'h0,         32'h600, 32'h404, 32'h700, 32'h404, 32'hFFFF_FFFF, 4'd1, 1'b0},
      '{OP_BR,   32'h0000_00FF, 32'h800, 32'h408, 32'h900, 32'h800, 32'h0000_00FF, 4'd3, 1'b0},
      '{OP_BR,   32'h0000_000F, 32'hA00, 32'h804, 32'hB00, 32'h800, 32'h0000_00FF, 4'd3, 1'b1},
      '{OP_BR,   32'hFFFF_FF00, 32'hC00, 32'h808, 32'hD00, 32'h808, 32'h0000_00FF, 4'd3, 1'b1},
      '{OP_BR,   32'hFFFF_FFFF, 32'h880, 32'h80C, 32'hE00, 32'h880, 32'h0000_00FF, 4'd3, 1'b1},
      '{OP_STEP, 32'h0,         32'h900, 32'h0,   32'h0,   32'h408, 32'hFFFF_FF00, 4'd2, 1'b1},
      '{OP_STEP, 32'h0,         32'h900, 32'h0,   32'h0,   32'h900, 32'hFFFF_FFFF, 4'd1, 1'b1},
      '{OP_STEP, 32'h0,         32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd1, 1'b1},
      '{OP_LOAD, 32'h0000_000F, 32'h40,  32'h0,   32'h0,   32'h40,  32'h0000_000F, 4'd1, 1'b0},
      '{OP_BR,   32'h0000_0005, 32'h80,  32'h44,  32'h90,  32'h80,  32'h0000_0005, 4'd3, 1'b0},
      '{OP_STEP, 32'h0,         32'h90,  32'h0,   32'h0,   32'h44,  32'h0000_000A, 4'd2, 1'b0}
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             load_valid, br_valid, step_valid;
   logic [PC_W-1:0]  load_pc, br_target, br_fallthru, br_reconv, step_pc;
   logic [LANES-1:0] load_mask, br_taken;
   logic [PC_W-1:0]  fetch_pc;
   logic [LANES-1:0] active_mask;
   logic [CNT_W-1:0] depth;
   logic             overflow;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #5 clk = ~clk;

   simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .load_valid(load_valid), .load_pc(load_pc), .load_mask(load_mask),
      .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
      .br_fallthru(br_fallthru), .br_reconv(br_reconv),
      .step_valid(step_valid), .step_pc(step_pc),
      .fetch_pc(fetch_pc), .active_mask(active_mask),
      .depth(depth), .overflow(overflow)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req, logic [31:0] e_pc, logic [31:0] e_mask,
                            int e_depth, logic e_ovf);
      check(req, "fetch_pc", fetch_pc, e_pc);
      check(req, "active_mask", active_mask, e_mask);
      check(req, "depth", 32'(depth), 32'(e_depth));
      check(req, "overflow", 32'(overflow), 32'(e_ovf));
   endtask

   task automatic idle();
      load_valid = 1'b0; br_valid = 1'b0; step_valid = 1'b0;
      load_pc = '0; load_mask = '0; br_taken = '0; br_target = '0;
      br_fallthru = '0; br_reconv = '0; step_pc = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0;
      idle();
      do_reset();
      check_all("R1", 32'h0, 32'h0, 0, 1'b0);

      // Table walk: R2..R8
      for (int i = 0; i < NVEC; i++) begin
         idle();
         case (VEC[i].op)
            OP_LOAD: begin load_valid = 1'b1; load_pc = VEC[i].p1; load_mask = VEC[i].m; end
            OP_BR:   begin br_valid = 1'b1; br_taken = VEC[i].m; br_target = VEC[i].p1;
                           br_fallthru = VEC[i].p2; br_reconv = VEC[i].p3; end
            default: begin step_valid = 1'b1; step_pc = VEC[i].p1; end
         endcase
         @(negedge clk);
         idle();
         check_all($sformatf("R3/R4/R5/R6/R7/R8 vec%0d", i), VEC[i].e_pc, VEC[i].e_mask,
                   int'(VEC[i].e_depth), VEC[i].e_ovf);
      end

      // R1 again after a busy stack
      do_reset();
      check_all("R1 rereset", 32'h0, 32'h0, 0, 1'b0);

      // R9: requests while empty do nothing
      br_valid = 1'b1; br_taken = 32'h0000_0003; br_target = 32'h50;
      br_fallthru = 32'h54; br_reconv = 32'h58;
      @(negedge clk);
      idle();
      check_all("R9 branch empty", 32'h0, 32'h0, 0, 1'b0);
      step_valid = 1'b1; step_pc = 32'h60;
      @(negedge clk);
      idle();
      check_all("R9 step empty", 32'h0, 32'h0, 0, 1'b0);

      // R10: load beats branch and step
      load_valid = 1'b1; load_pc = 32'h20; load_mask = 32'hFFFF_FFFF;
      br_valid = 1'b1; br_taken = 32'h1; br_target = 32'h70; br_fallthru = 32'h74; br_reconv = 32'h78;
      step_valid = 1'b1; step_pc = 32'h24;
      @(negedge clk);
      idle();
      check_all("R10 load wins", 32'h20, 32'hFFFF_FFFF, 1, 1'b0);

      // R10: branch beats step (uniform taken)
      br_valid = 1'b1; br_taken = 32'hFFFF_FFFF; br_target = 32'h30;
      br_fallthru = 32'h24; br_reconv = 32'h34;
      step_valid = 1'b1; step_pc = 32'h28;
      @(negedge clk);
      idle();
      check_all("R10 branch wins", 32'h30, 32'hFFFF_FFFF, 1, 1'b0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule